// File: doc/BRIEF.md
# I2C Sequencer Control Register

This block decodes the single write-only control word of an I2C command sequencer. A 32-bit write carries several independent commands: a start/stop code for the sequencer, a gated update of how many command bytes follow the slave address, a gated update of the quarter-bit-period delay, a request for a FIFO reset pulse, and direct line commands used for software bit-banging of SCL and SDA. The block holds the resulting state and presents it as registered outputs. The transfer engine and the FIFOs are outside the block.

Every field in the word has its own enable bit or its own no-change code, so one write can change any subset of the state. The direct line commands share bits [7:0] with the delay value. They apply only when the delay-load bit is clear and the sequencer is stopped. The FIFO reset request also stops the sequencer, which stays stopped until a later start command.

All outputs are registered. A write sampled on one rising clock edge shows on the outputs right after that edge.

Top module: `i2c_seq_ctrl`

## Requirements
- R1: After synchronous reset the run flag is 0, the byte count is 0, the delay equals the DEFAULT_DELAY parameter (25 by default), fifoReset is low, and both lines are released (enable 0, out value 1).
- R2: Write bits [13:12] form the run code. The value 3 sets the run flag, 2 clears it, and 0 or 1 leave it unchanged.
- R3: When write bit 11 is 1, bits [10:9] load the command byte count (0 to 3). When bit 11 is 0, the count is unchanged.
- R4: When write bit 8 is 1, bits [7:0] load the quarter-period delay. When bit 8 is 0, the delay is unchanged.
- R5: When write bit 8 is 0, bits [1:0] command SCL. Code 0 leaves it unchanged. Code 1 drives low (enable 1, out 0). Code 2 drives high (enable 1, out 1). Code 3 releases it (enable 0, out 1).
- R6: When write bit 8 is 0, bits [3:2] command SDA with the same encoding as SCL.
- R7: Line commands have no effect when the run flag is 1 at the time of the write. This includes a write whose run code stops the sequencer.
- R8: A write with bit 14 set raises fifoReset for exactly RESET_CYCLES (16) cycles, starting on the cycle after the write. A new request during the pulse restarts the full count.
- R9: A write with bit 14 set clears the run flag, and any run code in the same word is ignored. A later start command takes effect, even while the pulse is still active.
- R10: With wrEn low, no output changes except the countdown of an active fifoReset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 32 | Control word |
| runFlag | output | 1 | Sequencer run enable |
| cmdBytes | output | 2 | Command bytes after slave address |
| quarterDelay | output | 8 | Quarter bit period in clocks |
| fifoReset | output | 1 | FIFO reset pulse |
| sclOut | output | 1 | SCL drive value |
| sclEn | output | 1 | SCL drive enable |
| sdaOut | output | 1 | SDA drive value |
| sdaEn | output | 1 | SDA drive enable |

## Verification
All sixteen line-command combinations are swept with the sequencer stopped and again with it running. This separates the per-line encodings, exposes any swap between the SCL and SDA fields, and tests the run lockout. All 256 delay values and all four byte counts are written, each with its enable set and then cleared. This shows whether the enable bits gate their fields. Every run code is applied from both run states. Reset requests are issued alone, combined with a start code, and repeated mid-pulse, so that pulse length, restart and reset-over-start priority are each told apart. Idle cycles carry random data with the strobe low to show that the strobe gates every update.

// File: rtl/i2c_ctrl_pkg.sv
package i2c_ctrl_pkg;
  localparam int DELAY_W   = 8;
  localparam int BYTES_W   = 2;
  localparam int NUM_LINES = 2;
  localparam int LINE_SCL  = 0;
  localparam int LINE_SDA  = 1;

  // bit positions of the control word
  localparam int BIT_FIFO_RST   = 14;
  localparam int BIT_RUN_LO     = 12;
  localparam int BIT_BYTES_EN   = 11;
  localparam int BIT_BYTES_LO   = 9;
  localparam int BIT_DELAY_EN   = 8;
  localparam int BIT_SCL_LO     = 0;
  localparam int BIT_SDA_LO     = 2;

  typedef enum logic [1:0] {
    LINE_KEEP = 2'd0,
    LINE_LOW  = 2'd1,
    LINE_HIGH = 2'd2,
    LINE_FREE = 2'd3
  } lineCmd_e;

  typedef struct packed {
    logic                 setRun;
    logic                 clrRun;
    logic                 startReset;
    logic                 loadBytes;
    logic [BYTES_W-1:0]   bytesVal;
    logic                 loadDelay;
    logic [DELAY_W-1:0]   delayVal;
    logic                 lineWrite;
    lineCmd_e [NUM_LINES-1:0] lineCmd;
  } ctrlStrobes_t;
endpackage

// File: rtl/i2c_ctrl_decode.sv
module i2c_ctrl_decode
  import i2c_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              runNow,
  output ctrlStrobes_t      strobes
);
  logic [1:0] runCode;
  logic       resetReq;

  assign runCode  = wrData[BIT_RUN_LO +: 2];
  assign resetReq = wrEn && wrData[BIT_FIFO_RST];

  always_comb begin
    strobes            = '0;
    strobes.startReset = resetReq;
    // reset request wins over any run code in the same word
    strobes.setRun     = wrEn && !resetReq && (runCode == 2'd3);
    strobes.clrRun     = resetReq || (wrEn && (runCode == 2'd2));
    strobes.loadBytes  = wrEn && wrData[BIT_BYTES_EN];
    strobes.bytesVal   = wrData[BIT_BYTES_LO +: BYTES_W];
    strobes.loadDelay  = wrEn && wrData[BIT_DELAY_EN];
    strobes.delayVal   = wrData[DELAY_W-1:0];
    // direct pin control only when stopped before this write
    strobes.lineWrite  = wrEn && !wrData[BIT_DELAY_EN] && !runNow;
    strobes.lineCmd[LINE_SCL] = lineCmd_e'(wrData[BIT_SCL_LO +: 2]);
    strobes.lineCmd[LINE_SDA] = lineCmd_e'(wrData[BIT_SDA_LO +: 2]);
  end
endmodule

// File: rtl/i2c_ctrl_state.sv
module i2c_ctrl_state
  import i2c_ctrl_pkg::*;
#(
  parameter int                RESET_CYCLES  = 16,
  parameter logic [DELAY_W-1:0] DEFAULT_DELAY = 8'd25
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobes_t         strobes,
  output logic                 runFlag,
  output logic [BYTES_W-1:0]   cmdBytes,
  output logic [DELAY_W-1:0]   quarterDelay,
  output logic                 fifoReset,
  output logic [NUM_LINES-1:0] lineOut,
  output logic [NUM_LINES-1:0] lineEn
);
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESET_CYCLES);

  logic [CNT_W-1:0] rstCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      runFlag <= 1'b0;
    end else if (strobes.setRun) begin
      runFlag <= 1'b1;
    end else if (strobes.clrRun) begin
      runFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdBytes     <= '0;
      quarterDelay <= DEFAULT_DELAY;
    end else begin
      if (strobes.loadBytes) cmdBytes     <= strobes.bytesVal;
      if (strobes.loadDelay) quarterDelay <= strobes.delayVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rstCnt <= '0;
    end else if (strobes.startReset) begin
      rstCnt <= CNT_LOAD;
    end else if (rstCnt != '0) begin
      rstCnt <= rstCnt - 1'b1;
    end
  end
  assign fifoReset = (rstCnt != '0);

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    always_ff @(posedge clk) begin
      if (rst) begin
        lineEn[i]  <= 1'b0;
        lineOut[i] <= 1'b1;
      end else if (strobes.lineWrite) begin
        unique case (strobes.lineCmd[i])
          LINE_LOW:  begin lineEn[i] <= 1'b1; lineOut[i] <= 1'b0; end
          LINE_HIGH: begin lineEn[i] <= 1'b1; lineOut[i] <= 1'b1; end
          LINE_FREE: begin lineEn[i] <= 1'b0; lineOut[i] <= 1'b1; end
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_ctrl_pkg::*;
#(
  parameter int                RESET_CYCLES  = 16,
  parameter logic [DELAY_W-1:0] DEFAULT_DELAY = 8'd25
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic        runFlag,
  output logic [1:0]  cmdBytes,
  output logic [7:0]  quarterDelay,
  output logic        fifoReset,
  output logic        sclOut,
  output logic        sclEn,
  output logic        sdaOut,
  output logic        sdaEn
);
  ctrlStrobes_t         strobes;
  logic [NUM_LINES-1:0] lineOut;
  logic [NUM_LINES-1:0] lineEn;

  i2c_ctrl_decode #(.DATA_W(32)) uDecode (
    .wrEn    (wrEn),
    .wrData  (wrData),
    .runNow  (runFlag),
    .strobes (strobes)
  );

  i2c_ctrl_state #(
    .RESET_CYCLES  (RESET_CYCLES),
    .DEFAULT_DELAY (DEFAULT_DELAY)
  ) uState (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .runFlag      (runFlag),
    .cmdBytes     (cmdBytes),
    .quarterDelay (quarterDelay),
    .fifoReset    (fifoReset),
    .lineOut      (lineOut),
    .lineEn       (lineEn)
  );

  assign sclOut = lineOut[LINE_SCL];
  assign sclEn  = lineEn[LINE_SCL];
  assign sdaOut = lineOut[LINE_SDA];
  assign sdaEn  = lineEn[LINE_SDA];
endmodule

// File: rtl/i2c_seq_ctrl_chk.sv
module i2c_seq_ctrl_chk #(
  parameter int RESET_CYCLES = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic        runFlag,
  input logic [1:0]  cmdBytes,
  input logic [7:0]  quarterDelay,
  input logic        fifoReset,
  input logic        sclOut,
  input logic        sclEn,
  input logic        sdaOut,
  input logic        sdaEn
);
  int runLen;
  always_ff @(posedge clk) begin
    if (rst) runLen <= 0;
    else if (wrEn && wrData[14]) runLen <= 1;
    else if (fifoReset && runLen <= RESET_CYCLES) runLen <= runLen + 1;
    else runLen <= 0;
  end

  // R8: pulse never longer than the configured length
  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (rst)
    fifoReset |-> (runLen <= RESET_CYCLES));

  // R9: reset request stops sequencer and starts pulse
  assert_reset_stops_R9: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[14]) |=> (fifoReset && !runFlag));

  // R7: running sequencer locks line outputs
  assert_line_lock_R7: assert property (@(posedge clk) disable iff (rst)
    runFlag |=> ($stable(sclOut) && $stable(sclEn) && $stable(sdaOut) && $stable(sdaEn)));

  // R5: drive-low command on SCL when stopped
  assert_scl_low_R5: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrData[8] && !runFlag && wrData[1:0] == 2'd1) |=> (sclEn && !sclOut));

  // R6: release command on SDA when stopped
  assert_sda_free_R6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrData[8] && !runFlag && wrData[3:2] == 2'd3) |=> (!sdaEn && sdaOut));

  // R3: byte count holds without its enable
  assert_bytes_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && wrData[11]) |=> $stable(cmdBytes));

  // R4: delay holds without its enable
  assert_delay_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && wrData[8]) |=> $stable(quarterDelay));

  // R10: no strobe, run flag holds
  assert_idle_run_R10: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(runFlag));
endmodule

bind i2c_seq_ctrl i2c_seq_ctrl_chk #(.RESET_CYCLES(RESET_CYCLES)) uChk (.*);

// File: tb/sim_i2c_seq_ctrl.sv
module sim_i2c_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        runFlag, fifoReset, sclOut, sclEn, sdaOut, sdaEn;
  logic [1:0]  cmdBytes;
  logic [7:0]  quarterDelay;

  int checks = 0;
  int fails  = 0;

  // model state
  logic       mRun = 1'b0;
  logic [1:0] mBytes = 2'd0;
  logic [7:0] mDelay = 8'd25;
  int         mRst = 0;
  logic       mSclEn = 1'b0, mSclOut = 1'b1, mSdaEn = 1'b0, mSdaOut = 1'b1;

  i2c_seq_ctrl u0 (.*);

  always #5 clk = ~clk;

  task automatic cmp(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    cmp(tag, "runFlag", runFlag, mRun);
    cmp(tag, "cmdBytes", cmdBytes, mBytes);
    cmp(tag, "quarterDelay", quarterDelay, mDelay);
    cmp(tag, "fifoReset", fifoReset, (mRst > 0));
    cmp(tag, "sclEn", sclEn, mSclEn);
    cmp(tag, "sclOut", sclOut, mSclOut);
    cmp(tag, "sdaEn", sdaEn, mSdaEn);
    cmp(tag, "sdaOut", sdaOut, mSdaOut);
  endtask

  task automatic applyLine(input logic [1:0] c, ref logic en, ref logic o);
    if (c == 2'd1) begin en = 1'b1; o = 1'b0; end
    else if (c == 2'd2) begin en = 1'b1; o = 1'b1; end
    else if (c == 2'd3) begin en = 1'b0; o = 1'b1; end
  endtask

  // called at a negedge: drive, wait one cycle, update model, check
  task automatic step(input logic wr, input logic [31:0] d, input string tag);
    logic lineOk;
    wrEn = wr;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (wr) begin
      lineOk = !d[8] && !mRun;
      if (d[14]) begin
        mRun = 1'b0;
        mRst = 16;
      end else begin
        if (d[13:12] == 2'd3) mRun = 1'b1;
        else if (d[13:12] == 2'd2) mRun = 1'b0;
        if (mRst > 0) mRst--;
      end
      if (d[11]) mBytes = d[10:9];
      if (d[8]) mDelay = d[7:0];
      if (lineOk) begin
        applyLine(d[1:0], mSclEn, mSclOut);
        applyLine(d[3:2], mSdaEn, mSdaOut);
      end
    end else begin
      if (mRst > 0) mRst--;
    end
    checkAll(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkAll("R1");

    // R5 R6: all line codes while stopped
    for (int c = 0; c < 16; c++) step(1'b1, 32'(c), "R5_R6");
    for (int c = 15; c >= 0; c--) step(1'b1, 32'(c), "R6");

    // R4: all delays, then writes with enable clear
    for (int v = 0; v < 256; v++) step(1'b1, 32'h100 | 32'(v), "R4");
    for (int v = 0; v < 16; v++) step(1'b1, 32'(v * 17) & 32'hFF, "R4");

    // R3: all byte counts, with and without enable
    for (int b = 0; b < 4; b++) begin
      step(1'b1, 32'h800 | (32'(b) << 9), "R3");
      step(1'b1, (32'(3 - b) << 9) | 32'h100 | 32'(b), "R3");
    end

    // R2: every run code from both states
    for (int s = 0; s < 2; s++)
      for (int code = 0; code < 4; code++) begin
        step(1'b1, s ? 32'h3000 : 32'h2000, "R2");
        step(1'b1, 32'(code) << 12 | 32'h100 | 32'(40 + code), "R2");
      end

    // R7: sweep line codes while running
    step(1'b1, 32'h3000 | 32'h5, "R7");
    for (int c = 0; c < 16; c++) step(1'b1, 32'(c), "R7");
    step(1'b1, 32'h2000 | 32'hA, "R7");
    step(1'b1, 32'hF, "R7");
    step(1'b1, 32'h9, "R7");

    // R8: single pulse
    step(1'b1, 32'h4000, "R8");
    for (int i = 0; i < 20; i++) step(1'b0, 32'h0, "R8");
    // R8: restart mid-pulse
    step(1'b1, 32'h4000, "R8");
    for (int i = 0; i < 6; i++) step(1'b0, 32'h0, "R8");
    step(1'b1, 32'h4000, "R8");
    for (int i = 0; i < 20; i++) step(1'b0, 32'h0, "R8");

    // R9: run code in same word ignored, later start accepted during pulse
    step(1'b1, 32'h3000, "R9");
    step(1'b1, 32'h7000, "R9");
    step(1'b0, 32'h0, "R9");
    step(1'b1, 32'h3000, "R9");
    for (int i = 0; i < 18; i++) step(1'b0, 32'h0, "R9");

    // R10: random data with strobe low
    step(1'b1, 32'h2000 | 32'h6, "R10");
    for (int i = 0; i < 64; i++) step(1'b0, $urandom, "R10");
    step(1'b1, 32'h3000, "R10");
    for (int i = 0; i < 64; i++) step(1'b0, $urandom, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule